// File: doc/BRIEF.md
# Power Partition Gate Controller

This block owns the on/off state and the output isolation clamp of a set of switchable power partitions. Software reaches it through a small register bus. A toggle command flips the power state of one partition. A status word reports which partitions are powered. A release mask drops the isolation clamps of partitions that are powered. A separate register controls the clamp of a dedicated graphics rail. Each partition drives a power-enable output and a clamp-enable output.

A power change does not take effect at once. It occupies a settle window of a fixed, parameterised length, standing in for the rail's power-good response. While the window runs, a busy flag is readable and further toggle commands are refused. Isolation is made safe by construction. A partition that is being switched off has its clamp raised on the cycle the command is accepted. A release request only lowers a clamp on a partition that is fully powered and not in transition. An optional legacy mode cross-wires the release bits of partitions 3 and 4.

Top module: `pwr_part_ctrl`

## Requirements
- R1: A write to offset 0x030 with bit 8 set and a partition id in bits 7:0 flips the power state of that one partition. No other partition changes.
- R2: The flipped state appears on `part_pwr_en` exactly SETTLE_CYCLES clock edges after the edge that accepts the write. Bit 0 of a read at offset 0x03C is 1 from the accepting edge until the flip, and 0 otherwise.
- R3: A read at offset 0x038 returns one bit per partition, with bit i = 1 when partition i is powered. A read of an offset with no register returns 0.
- R4: A write to offset 0x034 clears the clamp of every partition i whose mask bit is set, if partition i is powered and not in a settle window. Mask bits for all other partitions have no effect.
- R5: With LEGACY_SWAP = 1, mask bit 3 of an offset 0x034 write acts on partition 4 and mask bit 4 acts on partition 3. All other bits map straight through.
- R6: Writing 0 to offset 0x2D4 releases the graphics-rail clamp, and writing any non-zero value re-applies it. Bit 0 of a read at 0x2D4 returns the clamp state, with 1 meaning clamped.
- R7: A toggle write whose id (bits 7:0) is at or above NUM_PARTS has no effect on power, clamps or busy.
- R8: A toggle write with bit 8 clear has no effect. A toggle write accepted while a settle window is running also has no effect.
- R9: An accepted toggle of a powered partition raises that partition's clamp on the accepting edge. A partition that is powered off is never unclamped.
- R10: After reset, all partitions are powered off and clamped, the rail is clamped, and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address while bus_rd is high |
| part_pwr_en | output | NUM_PARTS | Power enable per partition |
| part_clamp_en | output | NUM_PARTS | Isolation clamp enable per partition |
| rail_clamp_en | output | 1 | Graphics-rail clamp enable |

## Verification
Some properties are checked on every cycle:
- No partition is ever powered off while unclamped.
- The power vector is stable while idle.
- Each settle window changes at most one bit.
- A window lasts exactly SETTLE_CYCLES cycles.
- Malformed toggle writes (start bit clear or id out of range) never start a window.
- A zero written to the rail register releases the rail clamp.

Other behaviour can only be shown by the bench's scenarios, which compare against a cycle-accurate model:
- The legacy cross-wiring of the two release bits.
- The refusal of a second toggle during a window.
- Release requests for unpowered partitions being ignored.
- The contents of the status word.

// File: rtl/pgc_pkg.sv
`timescale 1ns/1ps
package pgc_pkg;
   // register byte offsets seen by software
   localparam int unsigned OFS_TOGGLE  = 32'h030;
   localparam int unsigned OFS_RELEASE = 32'h034;
   localparam int unsigned OFS_STATUS  = 32'h038;
   localparam int unsigned OFS_BUSY    = 32'h03C;
   localparam int unsigned OFS_RAIL    = 32'h2D4;

   // toggle word layout
   localparam int unsigned TOG_START_BIT = 8;
   localparam int unsigned TOG_ID_W      = 8;

   // release bits cross-wired in legacy mode
   localparam int unsigned SWAP_LO = 3;
   localparam int unsigned SWAP_HI = 4;

   function automatic bit part_count_ok(input int n);
      return (n == 7) || (n == 14) || (n == 23) || (n == 25);
   endfunction

   typedef struct packed {
      logic                tog_req;
      logic [TOG_ID_W-1:0] tog_id;
      logic                rel_req;
      logic                rail_wr;
      logic                rail_val;
   } pgc_cmd_t;
endpackage

// File: rtl/pgc_decode.sv
`timescale 1ns/1ps
module pgc_decode
   import pgc_pkg::*;
#(
   parameter int NUM_PARTS   = 7,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter bit LEGACY_SWAP = 1'b1
) (
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output pgc_cmd_t             cmd,
   output logic [NUM_PARTS-1:0] rel_mask
);
   localparam logic [TOG_ID_W-1:0] ID_LIMIT = TOG_ID_W'(NUM_PARTS);

   logic hit_tog, hit_rel, hit_rail;

   assign hit_tog  = bus_wr && (bus_addr == ADDR_W'(OFS_TOGGLE));
   assign hit_rel  = bus_wr && (bus_addr == ADDR_W'(OFS_RELEASE));
   assign hit_rail = bus_wr && (bus_addr == ADDR_W'(OFS_RAIL));

   always_comb begin
      cmd          = '0;
      cmd.tog_id   = bus_wdata[TOG_ID_W-1:0];
      cmd.tog_req  = hit_tog && bus_wdata[TOG_START_BIT] &&
                     (bus_wdata[TOG_ID_W-1:0] < ID_LIMIT);
      cmd.rel_req  = hit_rel;
      cmd.rail_wr  = hit_rail;
      cmd.rail_val = |bus_wdata;
   end

   // release mask routing, optionally cross-wired for the legacy pair
   for (genvar i = 0; i < NUM_PARTS; i++) begin : g_map
      if (LEGACY_SWAP && (i == SWAP_LO)) begin : g_lo
         assign rel_mask[i] = bus_wdata[SWAP_HI];
      end else if (LEGACY_SWAP && (i == SWAP_HI)) begin : g_hi
         assign rel_mask[i] = bus_wdata[SWAP_LO];
      end else begin : g_str
         assign rel_mask[i] = bus_wdata[i];
      end
   end
endmodule

// File: rtl/pgc_toggle_seq.sv
`timescale 1ns/1ps
module pgc_toggle_seq
   import pgc_pkg::*;
#(
   parameter int NUM_PARTS     = 7,
   parameter int SETTLE_CYCLES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tog_req,
   input  logic [TOG_ID_W-1:0]  tog_id,
   output logic [NUM_PARTS-1:0] pwr_state,
   output logic                 busy,
   output logic [NUM_PARTS-1:0] off_start,
   output logic [NUM_PARTS-1:0] inflight
);
   localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [NUM_PARTS-1:0] ONE = {{(NUM_PARTS-1){1'b0}}, 1'b1};

   logic [NUM_PARTS-1:0] pwr_q, tgt_q, req_oh;
   logic [CNT_W-1:0]     cnt_q;
   logic                 busy_q, accept;

   assign req_oh = ONE << tog_id;
   assign accept = tog_req && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q  <= '0;
         tgt_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(SETTLE_CYCLES - 1);
         tgt_q  <= req_oh;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            pwr_q  <= pwr_q ^ tgt_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign pwr_state = pwr_q;
   assign busy      = busy_q;
   assign off_start = accept ? (req_oh & pwr_q) : '0;
   assign inflight  = busy_q ? tgt_q : '0;
endmodule

// File: rtl/pgc_clamp_bank.sv
`timescale 1ns/1ps
module pgc_clamp_bank #(
   parameter int NUM_PARTS = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rel_req,
   input  logic [NUM_PARTS-1:0] rel_mask,
   input  logic [NUM_PARTS-1:0] pwr_state,
   input  logic [NUM_PARTS-1:0] off_start,
   input  logic [NUM_PARTS-1:0] inflight,
   output logic [NUM_PARTS-1:0] clamp
);
   for (genvar i = 0; i < NUM_PARTS; i++) begin : g_bit
      logic clamp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            clamp_q <= 1'b1;
         else if (off_start[i])
            clamp_q <= 1'b1;
         else if (rel_req && rel_mask[i] && pwr_state[i] && !inflight[i])
            clamp_q <= 1'b0;
      end
      assign clamp[i] = clamp_q;
   end
endmodule

// File: rtl/pwr_part_ctrl.sv
`timescale 1ns/1ps
module pwr_part_ctrl
   import pgc_pkg::*;
#(
   parameter int NUM_PARTS     = 7,
   parameter int SETTLE_CYCLES = 8,
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 32,
   parameter bit LEGACY_SWAP   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_PARTS-1:0] part_pwr_en,
   output logic [NUM_PARTS-1:0] part_clamp_en,
   output logic                 rail_clamp_en
);
   initial begin
      assert (part_count_ok(NUM_PARTS))
         else $error("NUM_PARTS must be 7, 14, 23 or 25");
      assert (SETTLE_CYCLES >= 1) else $error("SETTLE_CYCLES must be at least 1");
      assert (DATA_W >= NUM_PARTS && DATA_W > TOG_START_BIT)
         else $error("DATA_W too narrow");
      assert (ADDR_W >= 10) else $error("ADDR_W too narrow for the register map");
   end

   pgc_cmd_t             cmd;
   logic [NUM_PARTS-1:0] rel_mask, pwr_state, off_start, inflight, clamp;
   logic                 toggle_busy, rail_q;

   pgc_decode #(
      .NUM_PARTS(NUM_PARTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEGACY_SWAP(LEGACY_SWAP)
   ) u_dec (
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .cmd(cmd), .rel_mask(rel_mask)
   );

   pgc_toggle_seq #(
      .NUM_PARTS(NUM_PARTS), .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tog_req(cmd.tog_req), .tog_id(cmd.tog_id),
      .pwr_state(pwr_state), .busy(toggle_busy), .off_start(off_start), .inflight(inflight)
   );

   pgc_clamp_bank #(
      .NUM_PARTS(NUM_PARTS)
   ) u_clamp (
      .clk(clk), .rst_n(rst_n), .rel_req(cmd.rel_req), .rel_mask(rel_mask),
      .pwr_state(pwr_state), .off_start(off_start), .inflight(inflight), .clamp(clamp)
   );

   // graphics rail clamp: zero releases, non-zero clamps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rail_q <= 1'b1;
      else if (cmd.rail_wr)
         rail_q <= cmd.rail_val;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_W'(OFS_STATUS))
            bus_rdata[NUM_PARTS-1:0] = pwr_state;
         else if (bus_addr == ADDR_W'(OFS_BUSY))
            bus_rdata[0] = toggle_busy;
         else if (bus_addr == ADDR_W'(OFS_RAIL))
            bus_rdata[0] = rail_q;
      end
   end

   assign part_pwr_en   = pwr_state;
   assign part_clamp_en = clamp;
   assign rail_clamp_en = rail_q;
endmodule

// File: rtl/pgc_chk.sv
`timescale 1ns/1ps
module pgc_chk
   import pgc_pkg::*;
#(
   parameter int NUM_PARTS     = 7,
   parameter int SETTLE_CYCLES = 8,
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [NUM_PARTS-1:0] pwr,
   input logic [NUM_PARTS-1:0] clamp,
   input logic                 rail,
   input logic                 busy
);
   int unsigned win_len;
   logic        tog_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_len <= 0;
      else if (busy)   win_len <= win_len + 1;
      else             win_len <= 0;
   end

   assign tog_hit = bus_wr && (bus_addr == ADDR_W'(OFS_TOGGLE)) && !busy;

   assert_clamp_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pwr & ~clamp) == '0));

   assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(pwr));

   assert_single_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($countones(pwr ^ $past(pwr)) <= 1));

   assert_window_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (win_len == SETTLE_CYCLES));

   assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_hit && !bus_wdata[TOG_START_BIT]) |=> !busy);

   assert_bad_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tog_hit && (bus_wdata[TOG_ID_W-1:0] >= TOG_ID_W'(NUM_PARTS))) |=> !busy);

   assert_rail_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == ADDR_W'(OFS_RAIL)) && (bus_wdata == '0)) |=> !rail);
endmodule

bind pwr_part_ctrl pgc_chk #(
   .NUM_PARTS(NUM_PARTS), .SETTLE_CYCLES(SETTLE_CYCLES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .pwr(part_pwr_en), .clamp(part_clamp_en), .rail(rail_clamp_en), .busy(toggle_busy)
);

// File: tb/pwr_part_ctrl_test.sv
`timescale 1ns/1ps
module pwr_part_ctrl_test;
   localparam int NP     = 7;
   localparam int SETTLE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] part_pwr_en, part_clamp_en;
   logic        rail_clamp_en;

   int n_chk = 0, n_err = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_part_ctrl #(.NUM_PARTS(NP), .SETTLE_CYCLES(SETTLE), .LEGACY_SWAP(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .part_pwr_en(part_pwr_en),
      .part_clamp_en(part_clamp_en), .rail_clamp_en(rail_clamp_en)
   );

   // behavioural reference model
   logic [NP-1:0] m_pwr = '0, m_clamp = '1;
   logic          m_rail = 1'b1;
   bit            m_busy = 1'b0;
   int            m_cnt = 0, m_tid = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pwr = '0; m_clamp = '1; m_rail = 1'b1; m_busy = 1'b0; m_cnt = 0; m_tid = 0;
      end else begin
         bit            o_busy;
         int            o_tid;
         logic [NP-1:0] o_pwr;
         o_busy = m_busy; o_tid = m_tid; o_pwr = m_pwr;
         if (o_busy) begin
            if (m_cnt == 0) begin
               m_pwr[o_tid] = ~m_pwr[o_tid];
               m_busy = 1'b0;
            end else m_cnt = m_cnt - 1;
         end
         if (bus_wr) begin
            if (bus_addr == 12'h030 && bus_wdata[8] && int'(bus_wdata[7:0]) < NP && !o_busy) begin
               m_busy = 1'b1; m_cnt = SETTLE - 1; m_tid = int'(bus_wdata[7:0]);
               if (o_pwr[m_tid]) m_clamp[m_tid] = 1'b1;
            end
            if (bus_addr == 12'h034) begin
               for (int i = 0; i < NP; i++) begin
                  int src;
                  src = (i == 3) ? 4 : (i == 4) ? 3 : i;
                  if (bus_wdata[src] && o_pwr[i] && !(o_busy && o_tid == i)) m_clamp[i] = 1'b0;
               end
            end
            if (bus_addr == 12'h2D4) m_rail = (bus_wdata != 0);
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(32'(part_pwr_en), 32'(m_pwr), "R1 model power");
         chk(32'(part_clamp_en), 32'(m_clamp), "R4 model clamp");
         chk(32'(rail_clamp_en), 32'(m_rail), "R6 model rail");
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      chk(bus_rdata, exp, tag);
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (SETTLE + 3) @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(32'(part_pwr_en), 32'h0, "R10 power off");
      chk(32'(part_clamp_en), 32'h7F, "R10 clamped");
      chk(32'(rail_clamp_en), 32'h1, "R10 rail clamped");
      rd(12'h03C, 32'h0, "R10 busy clear");

      // R1 R2 power on partition 2, exact settle timing
      wr(12'h030, 32'h102);
      for (int k = 0; k <= SETTLE; k++) begin
         @(negedge clk);
         chk(32'(part_pwr_en[2]), (k >= SETTLE) ? 32'h1 : 32'h0, "R2 settle timing");
      end
      chk(32'(part_pwr_en), 32'h04, "R1 only partition 2 flipped");
      chk(32'(part_clamp_en[2]), 32'h1, "R4 still clamped before release");

      // R4 release powered 2 and unpowered 0
      wr(12'h034, 32'h05);
      @(negedge clk);
      chk(32'(part_clamp_en), 32'h7B, "R4 release only powered");

      // R5 legacy cross-wiring
      wr(12'h030, 32'h103); settle();
      wr(12'h030, 32'h104); settle();
      wr(12'h034, 32'h08);
      @(negedge clk);
      chk(32'(part_clamp_en[4]), 32'h0, "R5 bit3 releases partition 4");
      chk(32'(part_clamp_en[3]), 32'h1, "R5 partition 3 kept clamped");

      // R8 start bit clear
      wr(12'h030, 32'h003);
      rd(12'h03C, 32'h0, "R8 no start no busy");
      settle();
      chk(32'(part_pwr_en), 32'h1C, "R8 no start no change");

      // R7 out-of-range ids
      wr(12'h030, 32'h107);
      rd(12'h03C, 32'h0, "R7 id equal count ignored");
      wr(12'h030, 32'h1FF);
      rd(12'h03C, 32'h0, "R7 id 255 ignored");
      settle();
      chk(32'(part_pwr_en), 32'h1C, "R7 power unchanged");

      // R8 toggle while busy refused, R2 busy visible
      wr(12'h030, 32'h105);
      rd(12'h03C, 32'h1, "R2 busy during window");
      wr(12'h030, 32'h106);
      settle();
      chk(32'(part_pwr_en), 32'h3C, "R8 second toggle refused");
      rd(12'h03C, 32'h0, "R2 busy cleared");

      // R9 power off re-clamps on accept
      wr(12'h030, 32'h102);
      @(negedge clk);
      chk(32'(part_clamp_en[2]), 32'h1, "R9 clamp raised at accept");
      chk(32'(part_pwr_en[2]), 32'h1, "R9 still powered during window");
      settle();
      chk(32'(part_pwr_en), 32'h38, "R9 partition 2 off");
      wr(12'h034, 32'h04);
      @(negedge clk);
      chk(32'(part_clamp_en[2]), 32'h1, "R4 release of off partition ignored");

      // R6 rail clamp
      wr(12'h2D4, 32'h0);
      @(negedge clk);
      chk(32'(rail_clamp_en), 32'h0, "R6 zero releases rail");
      rd(12'h2D4, 32'h0, "R6 rail readback");
      wr(12'h2D4, 32'h5);
      rd(12'h2D4, 32'h1, "R6 non-zero clamps rail");

      // R3 status word and unmapped offset
      rd(12'h038, 32'h38, "R3 status word");
      rd(12'h100, 32'h0, "R3 unmapped reads zero");

      repeat (2) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule